// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the memory behind it. Each store is accepted in the cycle it is offered and parked in a small queue. The store then counts as complete while the memory write happens later. Every queue entry holds one block address and four 8-byte word slots, and each slot has its own valid bit. A later store to a block that already has a pending entry writes its word into that entry's slot and takes no new entry. The queue therefore holds more distinct stores than it has entries.

Entries go out to memory oldest first, one entry per memory handshake. Each memory write carries the block address, all four words and a slot mask showing which words are real. Stores flagged as uncached (I/O) are kept apart. They always open their own entry, and nothing merges into such an entry later. The entry at the head of the queue is being offered to memory, so it is frozen and accepts no merge.

Top module: `merge_wbuf`

## Requirements
- R1: While reset is applied and after it is released, with no store accepted, `mem_valid_o` is 0 and `st_ready_o` is 1.
- R2: A store is accepted on a rising edge where `st_valid_i` and `st_ready_o` are both 1. The byte address is 8-byte aligned. The block address is `st_addr_i[31:5]` and the word slot is `st_addr_i[4:3]`. When no merge target exists, the store opens a new entry whose mask has only that slot's bit set and whose other words read as zero.
- R3: A cached store whose block matches a pending cached entry that is not at the head is merged into that entry. The store's slot bit is ORed into the mask, its word is written, and no new entry is opened.
- R4: A merge into a slot that is already valid replaces that slot's word with the newer data.
- R5: A store with `st_io_i`=1 always opens a new entry, and no later store is ever merged into an entry opened by an I/O store.
- R6: The entry at the head of the queue accepts no merge. A store to its block opens a new entry, and the outputs presented to memory stay unchanged until the handshake.
- R7: Entries leave in the order they were opened, one per rising edge with `mem_valid_o` and `mem_ready_i` both 1. `mem_data_o` packs slot k in bits [64k+63:64k].
- R8: `st_ready_o` is 0 only when all 4 entries are occupied and the offered store has no merge target. A cached store with a merge target is accepted even when the queue is full.
- R9: `mem_valid_o` is 1 exactly when at least one entry is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered |
| st_ready_o | output | 1 | Store can be taken this cycle |
| st_addr_i | input | 32 | Store byte address, 8-byte aligned |
| st_data_i | input | 64 | Store word |
| st_io_i | input | 1 | Store targets uncached I/O space, never merged |
| mem_valid_o | output | 1 | Head entry offered to memory |
| mem_ready_i | input | 1 | Memory takes the head entry |
| mem_blk_o | output | 27 | Block address of head entry |
| mem_data_o | output | 256 | Four words of head entry, slot 0 lowest |
| mem_mask_o | output | 4 | Valid slots of head entry |

## Verification
The assertions assume that every offered store address is 8-byte aligned, and one of them checks this. They also assume that the memory side holds nothing beyond the handshake itself. The bench drives only aligned addresses and raises `mem_ready_i` for a single cycle at a time. It holds memory off while it builds a queue, so merges, I/O isolation, head exclusion and the full-queue stall all occur with the contents fully known. It then drains the queue and compares every entry against hand-derived block, mask and word values.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ALLOC = 2'd1,
    OP_MERGE = 2'd2
  } wb_op_e;
endpackage

// File: rtl/wb_entry.sv
module wb_entry
  import wb_pkg::*;
#(
  parameter int BLK_W  = 27,
  parameter int DATA_W = 64,
  parameter int WORDS  = 4,
  localparam int SLOT_W = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  wb_op_e                  op_i,
  input  logic                    clr_i,
  input  logic                    io_i,
  input  logic [BLK_W-1:0]        blk_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic                    vld_o,
  output logic                    io_o,
  output logic [BLK_W-1:0]        blk_o,
  output logic [WORDS-1:0]        mask_o,
  output logic [WORDS*DATA_W-1:0] data_o
);
  logic [WORDS-1:0] slot_dec;

  always_comb begin
    slot_dec = '0;
    slot_dec[slot_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      io_o   <= 1'b0;
      blk_o  <= '0;
      mask_o <= '0;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
      io_o   <= 1'b0;
      mask_o <= '0;
    end else if (op_i == OP_ALLOC) begin
      vld_o  <= 1'b1;
      io_o   <= io_i;
      blk_o  <= blk_i;
      mask_o <= slot_dec;
    end else if (op_i == OP_MERGE) begin
      mask_o <= mask_o | slot_dec;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[w*DATA_W +: DATA_W] <= '0;
      end else if (op_i == OP_ALLOC) begin
        data_o[w*DATA_W +: DATA_W] <= (slot_i == SLOT_W'(w)) ? data_i : '0;
      end else if (op_i == OP_MERGE && slot_i == SLOT_W'(w)) begin
        data_o[w*DATA_W +: DATA_W] <= data_i;
      end
    end
  end

  AST_MERGE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MERGE) |-> (vld_o && !io_o && !clr_i)); // R5
  AST_ALLOC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ALLOC) |-> !vld_o); // R2
endmodule

// File: rtl/wb_ring.sv
module wb_ring #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_o <= '0;
    end else begin
      if (push_i) tail_o <= nxt(tail_o);
      if (pop_i)  head_o <= nxt(head_o);
      if (push_i && !pop_i)      count_o <= count_o + 1'b1;
      else if (pop_i && !push_i) count_o <= count_o - 1'b1;
    end
  end

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign empty_o = (count_o == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R7
endmodule

// File: rtl/wb_match.sv
module wb_match #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 27,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            vld_i,
  input  logic [DEPTH-1:0]            io_i,
  input  logic [DEPTH-1:0][BLK_W-1:0] blk_i,
  input  logic [PTR_W-1:0]            head_i,
  input  logic [BLK_W-1:0]            st_blk_i,
  output logic [DEPTH-1:0]            hit_o,
  output logic [PTR_W-1:0]            hit_idx_o,
  output logic                        hit_any_o
);
  // head is frozen while offered to memory; I/O entries never take merges
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_o[i] = vld_i[i] && !io_i[i] && (head_i != PTR_W'(i)) &&
                      (blk_i[i] == st_blk_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_o[i]) hit_idx_o = PTR_W'(i);
    end
  end

  assign hit_any_o = |hit_o;
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 4,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int SLOT_W = $clog2(WORDS),
  localparam int BLK_W = ADDR_W - OFF_W - SLOT_W,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    st_valid_i,
  output logic                    st_ready_o,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [DATA_W-1:0]       st_data_i,
  input  logic                    st_io_i,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic [BLK_W-1:0]        mem_blk_o,
  output logic [WORDS*DATA_W-1:0] mem_data_o,
  output logic [WORDS-1:0]        mem_mask_o
);
  logic [BLK_W-1:0]  st_blk;
  logic [SLOT_W-1:0] st_slot;
  assign st_blk  = st_addr_i[ADDR_W-1 -: BLK_W];
  assign st_slot = st_addr_i[OFF_W +: SLOT_W];

  logic [DEPTH-1:0]                   ent_vld, ent_io;
  logic [DEPTH-1:0][BLK_W-1:0]        ent_blk;
  logic [DEPTH-1:0][WORDS-1:0]        ent_mask;
  logic [DEPTH-1:0][WORDS*DATA_W-1:0] ent_data;
  wb_op_e                             ent_op [DEPTH];
  logic [DEPTH-1:0]                   ent_clr;

  logic [PTR_W-1:0] head, tail, hit_idx;
  logic [CNT_W-1:0] count;
  logic             full, empty, hit_any;
  logic [DEPTH-1:0] hit;
  logic             accept, merge, push, pop;

  wb_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_match (
    .vld_i     (ent_vld),
    .io_i      (ent_io),
    .blk_i     (ent_blk),
    .head_i    (head),
    .st_blk_i  (st_blk),
    .hit_o     (hit),
    .hit_idx_o (hit_idx),
    .hit_any_o (hit_any)
  );

  assign merge      = hit_any && !st_io_i;
  assign st_ready_o = !full || merge;
  assign accept     = st_valid_i && st_ready_o;
  assign push       = accept && !merge;
  assign mem_valid_o = !empty;
  assign pop        = mem_valid_o && mem_ready_i;

  wb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .head_o  (head),
    .tail_o  (tail),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_op[i]  = OP_NONE;
      ent_clr[i] = pop && (head == PTR_W'(i));
      if (accept && merge && hit_idx == PTR_W'(i))      ent_op[i] = OP_MERGE;
      else if (push && tail == PTR_W'(i))               ent_op[i] = OP_ALLOC;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    wb_entry #(.BLK_W(BLK_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (ent_op[i]),
      .clr_i  (ent_clr[i]),
      .io_i   (st_io_i),
      .blk_i  (st_blk),
      .slot_i (st_slot),
      .data_i (st_data_i),
      .vld_o  (ent_vld[i]),
      .io_o   (ent_io[i]),
      .blk_o  (ent_blk[i]),
      .mask_o (ent_mask[i]),
      .data_o (ent_data[i])
    );
  end

  assign mem_blk_o  = ent_blk[head];
  assign mem_mask_o = ent_mask[head];
  assign mem_data_o = ent_data[head];

  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |-> (st_addr_i[OFF_W-1:0] == '0)); // R2
  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R3
  AST_ALLOC_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit_any && !pop) |=> (count == $past(count) + 1'b1)); // R2
  AST_MERGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit_any && !st_io_i && !pop) |=> (count == $past(count))); // R3
  AST_IO_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && st_io_i && !pop) |=> (count == $past(count) + 1'b1)); // R5
  AST_DRAIN_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !accept) |=> (count == $past(count) - 1'b1)); // R7
  AST_HEAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      ($stable(mem_blk_o) && $stable(mem_mask_o) && $stable(mem_data_o))); // R6
  AST_VALID_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_mask_o != '0)); // R9
endmodule

// File: tb/tb_merge_wbuf.sv
module tb_merge_wbuf;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         st_valid_i = 1'b0;
  logic         st_ready_o;
  logic [31:0]  st_addr_i = '0;
  logic [63:0]  st_data_i = '0;
  logic         st_io_i = 1'b0;
  logic         mem_valid_o;
  logic         mem_ready_i = 1'b0;
  logic [26:0]  mem_blk_o;
  logic [255:0] mem_data_o;
  logic [3:0]   mem_mask_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  merge_wbuf dut (
    .clk_i, .rst_ni, .st_valid_i, .st_ready_o, .st_addr_i, .st_data_i,
    .st_io_i, .mem_valid_o, .mem_ready_i, .mem_blk_o, .mem_data_o, .mem_mask_o
  );

  // {io, addr, data}
  localparam logic [96:0] STIM [8] = '{
    {1'b0, 32'h0000_0100, 64'h11},
    {1'b0, 32'h0000_0108, 64'h22},
    {1'b0, 32'h0000_0118, 64'h33},
    {1'b1, 32'h0000_0200, 64'h44},
    {1'b0, 32'h0000_0208, 64'h55},
    {1'b0, 32'h0000_0110, 64'h66},
    {1'b0, 32'h0000_0218, 64'h77},
    {1'b0, 32'h0000_0118, 64'h88}
  };

  task automatic chk(input logic ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic store(input logic io, input logic [31:0] a, input logic [63:0] d,
                       input logic exp_rdy, input string req);
    @(negedge clk_i);
    st_valid_i = 1'b1; st_io_i = io; st_addr_i = a; st_data_i = d;
    #1;
    chk(st_ready_o == exp_rdy, req, 256'(st_ready_o), 256'(exp_rdy));
    @(posedge clk_i);
    #1 st_valid_i = 1'b0;
  endtask

  task automatic drain(input logic [26:0] blk, input logic [3:0] mask,
                       input logic [255:0] data, input string req);
    @(negedge clk_i);
    chk(mem_valid_o, req, 256'(mem_valid_o), 256'(1));
    chk(mem_blk_o == blk && mem_mask_o == mask,
        req, {mem_mask_o, mem_blk_o}, {mask, blk});
    chk(mem_data_o == data, req, mem_data_o, data);
    mem_ready_i = 1'b1;
    @(posedge clk_i);
    #1 mem_ready_i = 1'b0;
  endtask

  task automatic finish_sim;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_sim();
  end

  initial begin
    #(CLK_PERIOD*2);
    chk(!mem_valid_o && st_ready_o, "R1 in reset", {mem_valid_o, st_ready_o}, 2'b01);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!mem_valid_o && st_ready_o, "R1 after reset", {mem_valid_o, st_ready_o}, 2'b01);

    // table: R2 alloc, R3 merge, R4 overwrite, R5 io, R6 head, R8 ready when full
    for (int k = 0; k < 8; k++) begin
      store(STIM[k][96], STIM[k][95:64], STIM[k][63:0], 1'b1, "R2/R3/R8 store accepted");
    end
    chk(mem_valid_o, "R9 pending entries", 256'(mem_valid_o), 256'(1));
    store(1'b0, 32'h0000_0300, 64'h99, 1'b0, "R8 full without merge target");

    drain(27'h8,  4'b0001, {64'h0, 64'h0, 64'h0, 64'h11}, "R7 R6 entry0 head kept apart");
    drain(27'h8,  4'b1110, {64'h88, 64'h66, 64'h22, 64'h0}, "R3 R4 entry1 merged and overwritten");
    drain(27'h10, 4'b0001, {64'h0, 64'h0, 64'h0, 64'h44}, "R5 entry2 io alone");
    drain(27'h10, 4'b1010, {64'h77, 64'h0, 64'h55, 64'h0}, "R5 entry3 not merged into io");
    @(negedge clk_i);
    chk(!mem_valid_o, "R9 empty after drain, R8 stalled store dropped",
        256'(mem_valid_o), 256'(0));

    // R6: second store to the head block opens a new entry
    store(1'b0, 32'h0000_0400, 64'hA, 1'b1, "R6 store");
    store(1'b0, 32'h0000_0408, 64'hB, 1'b1, "R6 store");
    drain(27'h20, 4'b0001, {192'h0, 64'hA}, "R6 head entry untouched");
    drain(27'h20, 4'b0010, {128'h0, 64'hB, 64'h0}, "R6 new entry");

    // R5: io stores never merge, nothing merges into io entries
    store(1'b1, 32'h0000_0600, 64'hC1, 1'b1, "R5 store");
    store(1'b1, 32'h0000_0608, 64'hC2, 1'b1, "R5 store");
    store(1'b1, 32'h0000_0610, 64'hC3, 1'b1, "R5 store");
    store(1'b0, 32'h0000_0618, 64'hC4, 1'b1, "R5 store");
    drain(27'h30, 4'b0001, {192'h0, 64'hC1}, "R5 io e0");
    drain(27'h30, 4'b0010, {128'h0, 64'hC2, 64'h0}, "R5 io e1");
    drain(27'h30, 4'b0100, {64'h0, 64'hC3, 128'h0}, "R5 io e2");
    drain(27'h30, 4'b1000, {64'hC4, 192'h0}, "R5 cached after io");
    @(negedge clk_i);
    chk(!mem_valid_o && st_ready_o, "R9 R1 idle again", {mem_valid_o, st_ready_o}, 2'b01);
    finish_sim();
  end
endmodule